// File: doc/BRIEF.md
# Store Miss Bypass Write Buffer

This block is a four-slot posted-write queue placed beside a core's first-level data cache. A store that misses the cache is not allocated there. It is parked in the queue, and the core continues without waiting. Later, the queue sends the store to the second-level memory through a valid/ready write port. Each slot holds one 16-byte store: address, data, byte-enable mask and a one-bit destination flag.

Slots leave strictly in arrival order. The destination flag sets how quickly writes may leave. Writes to scratchpad SRAM may go out once every 2 core cycles. Writes to the cache-backed region may go out once every 6 core cycles. Each destination has its own down-counter that enforces its gap.

The core is held off only when all four slots are occupied and no slot leaves in that cycle. When a slot leaves in the same cycle, a new store is taken even though the queue was full at the start of the cycle. The cache lookup itself, coherence and read forwarding are outside this block.

Top module: `store_bypass_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `st_stall` and `wr_valid` are low and the queue is empty.
- R2: With fewer than 4 slots occupied, `st_stall` is low and a store offered with `st_valid` high is taken at that clock edge.
- R3: With all 4 slots occupied and no write leaving in the cycle (`wr_valid` and `wr_ready` not both high), `st_stall` is high and the offered store is not taken.
- R4: With all 4 slots occupied and a write leaving in the same cycle, `st_stall` is low and the offered store is taken.
- R5: Writes leave in the order their stores were taken. Address, data, byte enables and destination flag are unchanged.
- R6: Destination flag 0 means scratchpad SRAM. Two writes with flag 0 leave at least 2 cycles apart. With `wr_ready` held high and such writes queued, they leave exactly every 2 cycles.
- R7: Destination flag 1 means the cache-backed region. Two writes with flag 1 leave at least 6 cycles apart. With `wr_ready` held high and such writes queued, they leave exactly every 6 cycles.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and the write payload holds steady on the next cycle.
- R9: `wr_valid` is low whenever the queue is empty. A store taken at edge t is offered on the write port in the cycle after t if its destination's gap has run out. The two destinations' gaps are timed separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core offers a missed store this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 128 | Store data, 16 bytes |
| st_be | input | 16 | Byte-enable mask |
| st_dest | input | 1 | Destination flag: 0 scratchpad SRAM, 1 cache-backed |
| st_stall | output | 1 | Store not taken this cycle; core must hold |
| wr_valid | output | 1 | Head write is offered downstream |
| wr_ready | input | 1 | Downstream takes the offered write |
| wr_addr | output | 32 | Head write address |
| wr_data | output | 128 | Head write data |
| wr_be | output | 16 | Head write byte enables |
| wr_dest | output | 1 | Head write destination flag |

## Verification
`st_stall` is combinational in the same cycle. It depends on the occupancy registered at the previous edge and on the current `wr_ready`, so the bench drives each cycle's inputs, waits one time unit, and compares `st_stall` before the next rising edge. A taken store can first appear on `wr_valid` one cycle after its accepting edge. Drain timing is due exactly a gap of 2 or 6 cycles after the previous write to the same destination. The bench models this with the cycle number of each destination's last write rather than a counter, and compares `wr_valid`, the payload and the hold behaviour in every cycle against that model.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_BYTES = 16;
    localparam int unsigned DATA_W     = DATA_BYTES * 8;
    localparam int unsigned NDEST      = 2;

    typedef enum logic {
        DST_SPAD = 1'b0,
        DST_L2C  = 1'b1
    } dest_e;

    typedef struct packed {
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
        logic [DATA_BYTES-1:0] be;
        dest_e                 dest;
    } slot_t;
endpackage

// File: rtl/sbb_queue.sv
module sbb_queue
    import sbb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  slot_t push_slot,
    input  logic  pop,
    output slot_t head,
    output logic  empty,
    output logic  full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic [PTR_W-1:0]  rd_ptr;
        logic [PTR_W-1:0]  wr_ptr;
        logic [CNT_W-1:0]  cnt;
    } qstate_t;

    qstate_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slots[st_q.wr_ptr] = push_slot;
            st_d.wr_ptr             = bump(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.slots[st_q.rd_ptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/sbb_pacer.sv
module sbb_pacer
    import sbb_pkg::*;
#(
    parameter int unsigned SPAD_GAP = 2,
    parameter int unsigned L2C_GAP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  dest_e            fire_dest,
    output logic [NDEST-1:0] open
);
    localparam int unsigned MAX_GAP = (SPAD_GAP > L2C_GAP) ? SPAD_GAP : L2C_GAP;
    localparam int unsigned CNT_W   = (MAX_GAP > 1) ? $clog2(MAX_GAP) : 1;

    for (genvar g = 0; g < NDEST; g++) begin : g_dest
        localparam int unsigned GAP = (g == 0) ? SPAD_GAP : L2C_GAP;
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (fire && (fire_dest == dest_e'(g))) begin
                cnt_d = CNT_W'(GAP - 1);
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign open[g] = (cnt_q == '0);
    end
endmodule

// File: rtl/store_bypass_buf.sv
module store_bypass_buf
    import sbb_pkg::*;
#(
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned SPAD_GAP = 2,
    parameter int unsigned L2C_GAP  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_BYTES-1:0] st_be,
    input  logic                  st_dest,
    output logic                  st_stall,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_BYTES-1:0] wr_be,
    output logic                  wr_dest
);
    slot_t            in_slot, head;
    logic             empty, full, fire, take;
    logic [NDEST-1:0] open;

    assign in_slot = '{addr: st_addr, data: st_data, be: st_be, dest: dest_e'(st_dest)};

    assign wr_valid = !empty && open[head.dest];
    assign fire     = wr_valid && wr_ready;
    assign st_stall = full && !fire;
    assign take     = st_valid && !st_stall;

    sbb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_slot (in_slot),
        .pop       (fire),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    sbb_pacer #(.SPAD_GAP(SPAD_GAP), .L2C_GAP(L2C_GAP)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_dest (head.dest),
        .open      (open)
    );

    assign wr_addr = head.addr;
    assign wr_data = head.data;
    assign wr_be   = head.be;
    assign wr_dest = head.dest;
endmodule

// File: rtl/store_bypass_buf_chk.sv
module store_bypass_buf_chk
    import sbb_pkg::*;
#(
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned SPAD_GAP = 2,
    parameter int unsigned L2C_GAP  = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  st_stall,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [DATA_BYTES-1:0] wr_be,
    input logic                  wr_dest
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1) + 1;
    localparam int unsigned GAP_W = $clog2(L2C_GAP + SPAD_GAP + 1);

    logic             fire, take;
    logic [OCC_W-1:0] occ_q;
    logic [GAP_W-1:0] since_s_q, since_c_q;

    assign fire = wr_valid && wr_ready;
    assign take = st_valid && !st_stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q     <= '0;
            since_s_q <= GAP_W'(SPAD_GAP);
            since_c_q <= GAP_W'(L2C_GAP);
        end else begin
            occ_q <= occ_q + OCC_W'(take) - OCC_W'(fire);
            if (fire && !wr_dest)                   since_s_q <= '0;
            else if (since_s_q < GAP_W'(SPAD_GAP))  since_s_q <= since_s_q + 1'b1;
            if (fire && wr_dest)                    since_c_q <= '0;
            else if (since_c_q < GAP_W'(L2C_GAP))   since_c_q <= since_c_q + 1'b1;
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH));

    a_r3_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (occ_q == OCC_W'(DEPTH)) && !fire);

    a_r4_take_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !st_stall);

    a_r6_spad_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_dest) |-> since_s_q >= GAP_W'(SPAD_GAP - 1));

    a_r7_l2c_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_dest) |-> since_c_q >= GAP_W'(L2C_GAP - 1));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)
                                   && $stable(wr_be) && $stable(wr_dest));

    a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !wr_valid);
endmodule

bind store_bypass_buf store_bypass_buf_chk #(
    .DEPTH(DEPTH), .SPAD_GAP(SPAD_GAP), .L2C_GAP(L2C_GAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_stall (st_stall),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .wr_dest  (wr_dest)
);

// File: tb/store_bypass_buf_bench.sv
module store_bypass_buf_bench;
    import sbb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int GAP_S      = 2;
    localparam int GAP_C      = 6;
    localparam int WATCHDOG   = 150000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  st_valid = 1'b0;
    logic [ADDR_W-1:0]     st_addr = '0;
    logic [DATA_W-1:0]     st_data = '0;
    logic [DATA_BYTES-1:0] st_be = '0;
    logic                  st_dest = 1'b0;
    logic                  st_stall;
    logic                  wr_valid;
    logic                  wr_ready = 1'b0;
    logic [ADDR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]     wr_data;
    logic [DATA_BYTES-1:0] wr_be;
    logic                  wr_dest;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wd = 0;
    int last_fire [2] = '{-100, -100};
    slot_t exp_q [$];
    logic  prev_hold = 1'b0;
    slot_t prev_pay;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_bypass_buf u_store_bypass_buf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .st_dest(st_dest), .st_stall(st_stall),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .wr_dest(wr_dest)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit dest_open(input int d);
        return cyc >= last_fire[d] + ((d == 0) ? GAP_S : GAP_C);
    endfunction

    // One cycle: inputs already driven after negedge; compare, then advance model.
    task automatic step();
        bit    exp_valid, exp_fire, exp_stall, take;
        slot_t cur;
        string tag;
        #1;
        exp_valid = (exp_q.size() > 0) && dest_open(int'(exp_q[0].dest));
        exp_fire  = exp_valid && wr_ready;
        exp_stall = (exp_q.size() == DEPTH) && !exp_fire;
        if (exp_q.size() == 0)          tag = "R9";
        else if (exp_q[0].dest == DST_SPAD) tag = "R6";
        else                            tag = "R7";
        check(wr_valid == exp_valid, tag, "wr_valid", 128'(wr_valid), 128'(exp_valid));
        if (exp_q.size() < DEPTH)  tag = "R2";
        else if (exp_fire)         tag = "R4";
        else                       tag = "R3";
        check(st_stall == exp_stall, tag, "st_stall", 128'(st_stall), 128'(exp_stall));
        cur = '{addr: wr_addr, data: wr_data, be: wr_be, dest: dest_e'(wr_dest)};
        if (prev_hold) begin
            // R8: a held write keeps its payload
            check(wr_valid && (cur == prev_pay), "R8", "held payload",
                  128'(cur.addr), 128'(prev_pay.addr));
        end
        if (exp_fire && exp_q.size() > 0) begin
            // R5: order and content preserved
            check(cur.addr == exp_q[0].addr, "R5", "wr_addr", 128'(cur.addr), 128'(exp_q[0].addr));
            check(cur.data == exp_q[0].data, "R5", "wr_data", cur.data, exp_q[0].data);
            check(cur.be == exp_q[0].be && cur.dest == exp_q[0].dest, "R5", "wr_be/dest",
                  128'({cur.be, cur.dest}), 128'({exp_q[0].be, exp_q[0].dest}));
            last_fire[int'(exp_q[0].dest)] = cyc;
            void'(exp_q.pop_front());
        end
        prev_hold = wr_valid && !wr_ready;
        prev_pay  = cur;
        take = st_valid && !exp_stall;
        if (take) exp_q.push_back('{addr: st_addr, data: st_data, be: st_be, dest: dest_e'(st_dest)});
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input bit dest, input bit rdy);
        st_valid = v;
        st_dest  = dest;
        st_addr  = $urandom;
        st_data  = {$urandom, $urandom, $urandom, $urandom};
        st_be    = 16'($urandom);
        wr_ready = rdy;
    endtask

    initial begin
        void'($urandom(32'h1d5e_ed01));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet during reset
        check(!st_stall, "R1", "st_stall in reset", 128'(st_stall), 128'(0));
        check(!wr_valid, "R1", "wr_valid in reset", 128'(wr_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && !st_stall, "R1", "outputs after reset",
              128'({wr_valid, st_stall}), 128'(0));

        // R3: fill with cache-backed stores while downstream is blocked
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, 1'b1, 1'b0);
            step();
        end
        // R4 and R7: release downstream while still pushing into a full queue
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 1'b1, 1'b1);
            step();
        end
        // Let it empty, then R6 cadence on scratchpad stores
        for (int i = 0; i < 30; i++) begin
            drive(1'b0, 1'b0, 1'b1);
            step();
        end
        for (int i = 0; i < 30; i++) begin
            drive(1'b1, 1'b0, 1'b1);
            step();
        end
        // R9: single store into empty queue appears next cycle
        for (int i = 0; i < 20; i++) begin
            drive(1'b0, 1'b0, 1'b1);
            step();
        end
        drive(1'b1, 1'b0, 1'b1);
        step();
        drive(1'b0, 1'b0, 1'b1);
        step();
        // Random mixture
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 10) < 6, $urandom % 2, ($urandom % 10) < 7);
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", wd, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule